// File: doc/BRIEF.md
# Interrupt Entry State Sequencer

This block is the CPU-side reaction to a maskable interrupt that has already won arbitration elsewhere. It owns the program counter, a status word carrying three flags, two save registers and a cause register. An accept strobe arrives with a 16-bit exception code and a handler address. The block then walks through five named steps, one per clock cycle, and ends by redirecting the program counter to the handler. While it walks, `busy_o` is high and every other request is ignored.

Outside an entry, the block takes single-cycle commands. A return command restores both the program counter and the status word from their save registers. An enable command clears the interrupt-disable flag and a disable command sets it. Two direct loads write the program counter or the status word. `ready_o` tells the external arbiter when a new maskable request may be accepted.

State machine: `ST_IDLE` goes to `ST_SAVE_PC` on a taken accept. It then passes `ST_SAVE_PC` → `ST_SAVE_PSW` → `ST_CAUSE` → `ST_FLAGS` → `ST_JUMP` unconditionally and returns to `ST_IDLE`. Status word bit positions:

| Bit | Flag | Meaning |
|-----|------|---------|
| 5 | ID | interrupt-disable flag |
| 6 | EP | exception-in-progress flag |
| 7 | NP | non-maskable-in-progress flag |

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, pc_o, saved_pc_o, saved_psw_o and cause_o are 0, psw_o is 0x0000_0020 (ID = bit 5 set), busy_o is 0 and ready_o is 0.
- R2: An accept is taken only when the block is idle and ID (bit 5) and NP (bit 7) are both 0. Any other accept has no effect on any output.
- R3: One cycle after a taken accept, busy_o is 1. One cycle later, saved_pc_o holds the program counter value from before the entry.
- R4: In the next step, saved_psw_o receives the status word from before the entry.
- R5: In the next step, cause_o[15:0] receives the accepted code and cause_o[31:16] stays unchanged.
- R6: In the next step, psw_o gets ID (bit 5) set to 1 and EP (bit 6) cleared to 0. All other bits stay unchanged.
- R7: In the last step, pc_o loads the handler address given with the accept and busy_o falls. busy_o is high for exactly five cycles per entry.
- R8: When idle, a return command sets pc_o to saved_pc_o and psw_o to saved_psw_o in one cycle.
- R9: When idle, the enable command clears ID (bit 5). The disable command sets ID. If both are given together, enable wins.
- R10: When idle, the program counter load and the status word load replace their registers in one cycle. While busy, every command and load is ignored.
- R11: ready_o is 1 exactly when the block is idle and ID and NP are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| accept_i | input | 1 | interrupt accept strobe |
| code_i | input | 16 | exception code sent with the accept |
| handler_i | input | 32 | handler address sent with the accept |
| irq_en_i | input | 1 | clear the ID flag |
| irq_dis_i | input | 1 | set the ID flag |
| ret_i | input | 1 | restore PC and status word from the save registers |
| pc_wr_i | input | 1 | load the program counter |
| pc_wdata_i | input | 32 | program counter load value |
| psw_wr_i | input | 1 | load the status word |
| psw_wdata_i | input | 32 | status word load value |
| pc_o | output | 32 | program counter |
| psw_o | output | 32 | status word |
| saved_pc_o | output | 32 | saved program counter |
| saved_psw_o | output | 32 | saved status word |
| cause_o | output | 32 | exception cause register |
| busy_o | output | 1 | entry sequence in progress |
| ready_o | output | 1 | a maskable accept would be taken |

## Verification
Every register is visible at a port, so each wrong step in the sequencer shows up on its own output one cycle after the step. Examples are a skipped state, two steps swapped, or a save that reads the value after the flag update. The bench compares all outputs after every cycle of each entry, so an error is reported in the same cycle it becomes visible. A gating fault appears one cycle later: either an accept that should be ignored raises `busy_o`, or a command issued while busy changes a register. Return faults and flag-command faults show on `pc_o` and `psw_o` right after the command cycle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE_PC,
        ST_SAVE_PSW,
        ST_CAUSE,
        ST_FLAGS,
        ST_JUMP
    } entry_state_e;

    localparam int unsigned ID_BIT = 5;
    localparam int unsigned EP_BIT = 6;
    localparam int unsigned NP_BIT = 7;

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic id_i,
    input  logic np_i,
    output logic take_o,
    output logic ready_o,
    output logic busy_o,
    output logic save_pc_o,
    output logic save_psw_o,
    output logic cause_o,
    output logic flags_o,
    output logic jump_o
);

    entry_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (take_o) state_d = ST_SAVE_PC;
            ST_SAVE_PC:  state_d = ST_SAVE_PSW;
            ST_SAVE_PSW: state_d = ST_CAUSE;
            ST_CAUSE:    state_d = ST_FLAGS;
            ST_FLAGS:    state_d = ST_JUMP;
            ST_JUMP:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o     = 1'b1;
        save_pc_o  = 1'b0;
        save_psw_o = 1'b0;
        cause_o    = 1'b0;
        flags_o    = 1'b0;
        jump_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:     busy_o     = 1'b0;
            ST_SAVE_PC:  save_pc_o  = 1'b1;
            ST_SAVE_PSW: save_psw_o = 1'b1;
            ST_CAUSE:    cause_o    = 1'b1;
            ST_FLAGS:    flags_o    = 1'b1;
            ST_JUMP:     jump_o     = 1'b1;
            default:     busy_o     = 1'b0;
        endcase
        ready_o = !busy_o && !id_i && !np_i;
        take_o  = accept_i && ready_o;
    end

    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !busy_o && (id_i || np_i)) |=> !busy_o);

    p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAVE_PC) |=> (state_q == ST_SAVE_PSW));

    p_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUMP) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/irq_entry_regs.sv
module irq_entry_regs
    import irq_entry_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              busy_i,
    input  logic              save_pc_i,
    input  logic              save_psw_i,
    input  logic              cause_i,
    input  logic              flags_i,
    input  logic              jump_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [DATA_W-1:0] handler_i,
    input  logic              irq_en_i,
    input  logic              irq_dis_i,
    input  logic              ret_i,
    input  logic              pc_wr_i,
    input  logic [DATA_W-1:0] pc_wdata_i,
    input  logic              psw_wr_i,
    input  logic [DATA_W-1:0] psw_wdata_i,
    output logic [DATA_W-1:0] pc_o,
    output logic [DATA_W-1:0] psw_o,
    output logic [DATA_W-1:0] saved_pc_o,
    output logic [DATA_W-1:0] saved_psw_o,
    output logic [DATA_W-1:0] cause_o
);

    localparam logic [DATA_W-1:0] PSW_RESET = DATA_W'(1) << ID_BIT;

    logic [CODE_W-1:0] code_q;
    logic [DATA_W-1:0] handler_q;
    logic              cmd_en;

    assign cmd_en = !busy_i && !take_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o        <= '0;
            psw_o       <= PSW_RESET;
            saved_pc_o  <= '0;
            saved_psw_o <= '0;
            cause_o     <= '0;
            code_q      <= '0;
            handler_q   <= '0;
        end else begin
            if (take_i) begin
                code_q    <= code_i;
                handler_q <= handler_i;
            end
            if (save_pc_i)  saved_pc_o  <= pc_o;
            if (save_psw_i) saved_psw_o <= psw_o;
            if (cause_i)    cause_o[CODE_W-1:0] <= code_q;
            if (flags_i) begin
                psw_o[ID_BIT] <= 1'b1;
                psw_o[EP_BIT] <= 1'b0;
            end
            if (jump_i) pc_o <= handler_q;
            if (cmd_en) begin
                if (ret_i) begin
                    pc_o  <= saved_pc_o;
                    psw_o <= saved_psw_o;
                end else begin
                    if (pc_wr_i) pc_o <= pc_wdata_i;
                    if (psw_wr_i)       psw_o <= psw_wdata_i;
                    else if (irq_en_i)  psw_o[ID_BIT] <= 1'b0;
                    else if (irq_dis_i) psw_o[ID_BIT] <= 1'b1;
                end
            end
        end
    end

    p_save_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        save_pc_i |=> (saved_pc_o == $past(pc_o)));

    p_save_psw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        save_psw_i |=> (saved_psw_o == $past(psw_o)));

    p_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cause_i |=> (cause_o[DATA_W-1:CODE_W] == $past(cause_o[DATA_W-1:CODE_W])));

    p_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flags_i |=> (psw_o[ID_BIT] && !psw_o[EP_BIT]));

    p_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
        jump_i |=> (pc_o == $past(handler_q)));

    p_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && ret_i) |=> (pc_o == $past(saved_pc_o) && psw_o == $past(saved_psw_o)));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [DATA_W-1:0] handler_i,
    input  logic              irq_en_i,
    input  logic              irq_dis_i,
    input  logic              ret_i,
    input  logic              pc_wr_i,
    input  logic [DATA_W-1:0] pc_wdata_i,
    input  logic              psw_wr_i,
    input  logic [DATA_W-1:0] psw_wdata_i,
    output logic [DATA_W-1:0] pc_o,
    output logic [DATA_W-1:0] psw_o,
    output logic [DATA_W-1:0] saved_pc_o,
    output logic [DATA_W-1:0] saved_psw_o,
    output logic [DATA_W-1:0] cause_o,
    output logic              busy_o,
    output logic              ready_o
);

    logic take, save_pc, save_psw, cause_st, flags_st, jump_st;

    irq_entry_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept_i),
        .id_i       (psw_o[ID_BIT]),
        .np_i       (psw_o[NP_BIT]),
        .take_o     (take),
        .ready_o    (ready_o),
        .busy_o     (busy_o),
        .save_pc_o  (save_pc),
        .save_psw_o (save_psw),
        .cause_o    (cause_st),
        .flags_o    (flags_st),
        .jump_o     (jump_st)
    );

    irq_entry_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take),
        .busy_i      (busy_o),
        .save_pc_i   (save_pc),
        .save_psw_i  (save_psw),
        .cause_i     (cause_st),
        .flags_i     (flags_st),
        .jump_i      (jump_st),
        .code_i      (code_i),
        .handler_i   (handler_i),
        .irq_en_i    (irq_en_i),
        .irq_dis_i   (irq_dis_i),
        .ret_i       (ret_i),
        .pc_wr_i     (pc_wr_i),
        .pc_wdata_i  (pc_wdata_i),
        .psw_wr_i    (psw_wr_i),
        .psw_wdata_i (psw_wdata_i),
        .pc_o        (pc_o),
        .psw_o       (psw_o),
        .saved_pc_o  (saved_pc_o),
        .saved_psw_o (saved_psw_o),
        .cause_o     (cause_o)
    );

endmodule

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        accept_i = 1'b0;
    logic [15:0] code_i = '0;
    logic [31:0] handler_i = '0;
    logic        irq_en_i = 1'b0, irq_dis_i = 1'b0, ret_i = 1'b0;
    logic        pc_wr_i = 1'b0, psw_wr_i = 1'b0;
    logic [31:0] pc_wdata_i = '0, psw_wdata_i = '0;
    logic [31:0] pc_o, psw_o, saved_pc_o, saved_psw_o, cause_o;
    logic        busy_o, ready_o;

    always #2.5 clk = ~clk;

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .code_i(code_i),
        .handler_i(handler_i), .irq_en_i(irq_en_i), .irq_dis_i(irq_dis_i),
        .ret_i(ret_i), .pc_wr_i(pc_wr_i), .pc_wdata_i(pc_wdata_i),
        .psw_wr_i(psw_wr_i), .psw_wdata_i(psw_wdata_i), .pc_o(pc_o),
        .psw_o(psw_o), .saved_pc_o(saved_pc_o), .saved_psw_o(saved_psw_o),
        .cause_o(cause_o), .busy_o(busy_o), .ready_o(ready_o)
    );

    typedef struct {
        string       req;
        logic [31:0] pc, psw, spc, spsw, cause;
        logic        busy, ready;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0, n_bad = 0;
    bit   done = 1'b0;

    logic [31:0] m_pc = 0, m_psw = 32'h20, m_spc = 0, m_spsw = 0, m_cause = 0;
    logic        m_busy = 0;

    task automatic push(string req);
        exp_t e;
        e.req = req; e.pc = m_pc; e.psw = m_psw; e.spc = m_spc;
        e.spsw = m_spsw; e.cause = m_cause; e.busy = m_busy;
        e.ready = !m_busy && !m_psw[5] && !m_psw[7];
        q.push_back(e);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        accept_i = 0; irq_en_i = 0; irq_dis_i = 0; ret_i = 0;
        pc_wr_i = 0; psw_wr_i = 0;
    endtask

    // monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (pc_o !== e.pc || psw_o !== e.psw || saved_pc_o !== e.spc ||
                    saved_psw_o !== e.spsw || cause_o !== e.cause ||
                    busy_o !== e.busy || ready_o !== e.ready) begin
                    n_bad++;
                    $display("FAIL %s: got pc=%h psw=%h spc=%h spsw=%h cause=%h busy=%b ready=%b exp pc=%h psw=%h spc=%h spsw=%h cause=%h busy=%b ready=%b",
                        e.req, pc_o, psw_o, saved_pc_o, saved_psw_o, cause_o, busy_o, ready_o,
                        e.pc, e.psw, e.spc, e.spsw, e.cause, e.busy, e.ready);
                end
            end
        end
    end

    // entry driver; noise drives accept, commands and loads while busy (R10)
    task automatic entry(logic [15:0] code, logic [31:0] hnd, bit noise);
        accept_i = 1; code_i = code; handler_i = hnd;
        cyc();
        clear_in();
        if (noise) begin
            accept_i = 1; irq_en_i = 1; ret_i = 1; pc_wr_i = 1; psw_wr_i = 1;
            pc_wdata_i = 32'hDEAD_0000; psw_wdata_i = 32'h0000_FFFF;
        end
        m_busy = 1; push("R3 busy");
        cyc(); m_spc = m_pc;                 push("R3 save pc");
        cyc(); m_spsw = m_psw;               push("R4 save psw");
        cyc(); m_cause[15:0] = code;         push("R5 cause");
        cyc(); m_psw[5] = 1; m_psw[6] = 0;   push("R6 flags");
        cyc(); clear_in();
        m_pc = hnd; m_busy = 0;              push("R7 jump");
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        push("R1 reset");
        // R2: accept while ID set is ignored
        accept_i = 1; code_i = 16'h0007; handler_i = 32'h300;
        cyc(); clear_in(); push("R2 blocked by ID");
        // R9 / R11: enable clears ID, ready rises
        irq_en_i = 1; cyc(); clear_in(); m_psw[5] = 0; push("R9 enable");
        pc_wr_i = 1; pc_wdata_i = 32'h1000; cyc(); clear_in();
        m_pc = 32'h1000; push("R10 pc load");
        psw_wr_i = 1; psw_wdata_i = 32'h80; cyc(); clear_in();
        m_psw = 32'h80; push("R11 NP blocks ready");
        accept_i = 1; cyc(); clear_in(); push("R2 blocked by NP");
        psw_wr_i = 1; psw_wdata_i = 32'h40; cyc(); clear_in();
        m_psw = 32'h40; push("R10 psw load");
        entry(16'h0050, 32'h200, 1'b0);
        // R8 return
        ret_i = 1; cyc(); clear_in();
        m_pc = m_spc; m_psw = m_spsw; push("R8 return");
        irq_dis_i = 1; cyc(); clear_in(); m_psw[5] = 1; push("R9 disable");
        irq_en_i = 1; irq_dis_i = 1; cyc(); clear_in(); m_psw[5] = 0; push("R9 enable wins");
        pc_wr_i = 1; pc_wdata_i = 32'h2000; psw_wr_i = 1; psw_wdata_i = 32'hF040;
        cyc(); clear_in(); m_pc = 32'h2000; m_psw = 32'hF040; push("R10 dual load");
        entry(16'h1234, 32'h480, 1'b1);
        ret_i = 1; cyc(); clear_in();
        m_pc = m_spc; m_psw = m_spsw; push("R8 return 2");
        cyc(); cyc();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule